// File: doc/BRIEF.md
# Message Object Interrupt Identifier

This block gathers the interrupt sources of a CAN message controller into one identifier code and one active-low interrupt line. It keeps one pending flag for each of the message objects and one latched status flag. An object's flag is set when the message handler reports a good reception or a good transmission for that object, provided that the object has the matching per-object enable. The flag is cleared by an explicit clear strobe. The status flag is raised by completed transfers or bus errors when the status-change enable is set. It is also raised by any edge of the bus-off or warning levels when the error enable is set. A read strobe of the status register clears it.

Each cycle a priority encoder picks the source to report, and the result is registered. The status source always wins. Among the objects, the lowest object number wins. The line is driven low only while the module enable is set and something is pending.

Top module: `msg_irq_ident`

## Requirements
- R1: With no object flag and no status flag pending, `int_id` is 0x0000.
- R2: With object flags pending and no status flag, `int_id` holds the object number (index + 1, so 1 to 32) of the lowest-indexed pending object.
- R3: A pending status flag makes `int_id` 0x8000, whatever object flags are pending.
- R4: `rx_done` with object index `rx_obj` sets that object's flag only when `rx_irq_en[rx_obj]` is 1. Otherwise `obj_pend` is unchanged.
- R5: `tx_done` with object index `tx_obj` sets that object's flag only when `tx_irq_en[tx_obj]` is 1. Otherwise `obj_pend` is unchanged.
- R6: `clr_stb` with index `clr_obj` clears that object's flag. A set of the same object in the same cycle takes precedence.
- R7: With `stat_chg_en` = 1, either `xfer_ok` or `lec_upd` with `lec_code` in 1 to 6 latches the status flag. Codes 0 and 7 do not latch it, and neither does any event while `stat_chg_en` = 0.
- R8: With `err_chg_en` = 1, any rising or falling edge of `bus_off` or of `err_warn` latches the status flag.
- R9: `stat_rd` clears the status flag. A new status event in the same cycle takes precedence.
- R10: While `irq_en` = 0, `irq_n` is 1.
- R11: While `irq_en` = 1, `irq_n` is 0 exactly when `int_id` is non-zero. It returns to 1 once every source has been cleared.
- R12: `obj_pend` changes on the clock edge that takes the event. `int_id` and `irq_n` follow one clock later.
- R13: After reset, `int_id` is 0, `irq_n` is 1 and `obj_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Module interrupt line enable |
| stat_chg_en | input | 1 | Enable for status interrupts from transfers and bus errors |
| err_chg_en | input | 1 | Enable for status interrupts from error-state edges |
| rx_done | input | 1 | Good reception strobe |
| rx_obj | input | 5 | Object index of the reception |
| tx_done | input | 1 | Good transmission strobe |
| tx_obj | input | 5 | Object index of the transmission |
| rx_irq_en | input | 32 | Per-object receive interrupt enables |
| tx_irq_en | input | 32 | Per-object transmit interrupt enables |
| clr_stb | input | 1 | Clear one object's pending flag |
| clr_obj | input | 5 | Object index to clear |
| xfer_ok | input | 1 | Transfer completed without error |
| lec_upd | input | 1 | Last-error code update strobe |
| lec_code | input | 3 | Error code that comes with `lec_upd` |
| bus_off | input | 1 | Bus-off level |
| err_warn | input | 1 | Error-warning level |
| stat_rd | input | 1 | Status register read strobe |
| int_id | output | 16 | Registered interrupt identifier |
| irq_n | output | 1 | Active-low interrupt line |
| obj_pend | output | 32 | Per-object pending flags |

## Verification
If a pending flag is lost or set by mistake, `obj_pend` shows it right after the edge that took the event. `int_id` shows the wrong object one cycle later. If the status latch or the edge detector goes wrong, `int_id` shows a missing or unexpected 0x8000 within one cycle of the triggering event or read. This holds even when object flags are pending underneath. A fault in priority or in gating shows as a wrong code or a wrong `irq_n` level on the cycle after the pending set changes, so the bench compares all three outputs on every cycle.

// File: rtl/irqid_pkg.sv
package irqid_pkg;
  localparam int unsigned LEC_W = 3;

  // bus error codes are 1..6; 0 means none and 7 is a software marker
  function automatic logic is_bus_err(input logic [LEC_W-1:0] code);
    return (code != '0) && (code != {LEC_W{1'b1}});
  endfunction
endpackage

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int unsigned NUM_OBJ = 32,
  localparam int unsigned IW = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_done,
  input  logic [IW-1:0]      rx_obj,
  input  logic               tx_done,
  input  logic [IW-1:0]      tx_obj,
  input  logic [NUM_OBJ-1:0] rx_irq_en,
  input  logic [NUM_OBJ-1:0] tx_irq_en,
  input  logic               clr_stb,
  input  logic [IW-1:0]      clr_obj,
  output logic [NUM_OBJ-1:0] pend
);
  logic [NUM_OBJ-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (clr_stb && (clr_obj == IW'(i))) pend_nxt[i] = 1'b0;
      if ((rx_done && (rx_obj == IW'(i)) && rx_irq_en[i]) ||
          (tx_done && (tx_obj == IW'(i)) && tx_irq_en[i]))
        pend_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  // R4: a reception on a disabled object leaves its flag clear
  a_r4_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_irq_en[rx_obj] && !tx_done && !pend[rx_obj])
      |=> !pend[$past(rx_obj)]);

  // R6: a clear with no competing set drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !rx_done && !tx_done) |=> !pend[$past(clr_obj)]);
endmodule

// File: rtl/stat_src.sv
module stat_src
  import irqid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_chg_en,
  input  logic             err_chg_en,
  input  logic             xfer_ok,
  input  logic             lec_upd,
  input  logic [LEC_W-1:0] lec_code,
  input  logic             bus_off,
  input  logic             err_warn,
  input  logic             stat_rd,
  output logic             stat_pend
);
  logic boff_q, warn_q;
  logic chg_evt, err_evt, stat_set, stat_nxt;

  always_comb begin
    chg_evt  = stat_chg_en && (xfer_ok || (lec_upd && is_bus_err(lec_code)));
    err_evt  = err_chg_en && ((bus_off != boff_q) || (err_warn != warn_q));
    stat_set = chg_evt || err_evt;
    stat_nxt = stat_set || (stat_pend && !stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      boff_q    <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      stat_pend <= stat_nxt;
      boff_q    <= bus_off;
      warn_q    <= err_warn;
    end
  end

  // R8: an edge of the bus-off level with the error enable latches status
  a_r8_boff_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (err_chg_en && (bus_off != $past(bus_off))) |=> stat_pend);

  // R9: a read with no new event clears status
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !xfer_ok && !lec_upd && !err_chg_en) |=> !stat_pend);

  // R7: with both enables off the latch can only hold or fall
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_chg_en && !err_chg_en && !stat_pend) |=> !stat_pend);
endmodule

// File: rtl/id_encode.sv
module id_encode #(
  parameter int unsigned NUM_OBJ   = 32,
  parameter int unsigned ID_W      = 16,
  parameter logic [ID_W-1:0] STAT_ID = 16'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OBJ-1:0] pend,
  input  logic               stat_pend,
  output logic [ID_W-1:0]    int_id
);
  logic [ID_W-1:0] id_nxt;

  always_comb begin
    id_nxt = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend[i]) id_nxt = ID_W'(i + 1);
    end
    if (stat_pend) id_nxt = STAT_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_id <= '0;
    else        int_id <= id_nxt;
  end

  // R3: a pending status flag is reported on the next cycle
  a_r3_stat_first: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat_pend) |-> (int_id == STAT_ID));

  // R2: object-only pending yields a code in the object range
  a_r2_obj_range: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend != '0) && !$past(stat_pend))
      |-> ((int_id != '0) && (int_id <= ID_W'(NUM_OBJ))));

  // R1: nothing pending reads as zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend == '0) && !$past(stat_pend)) |-> (int_id == '0));
endmodule

// File: rtl/msg_irq_ident.sv
module msg_irq_ident
  import irqid_pkg::*;
#(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned ID_W    = 16,
  localparam int unsigned IW     = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_en,
  input  logic               stat_chg_en,
  input  logic               err_chg_en,
  input  logic               rx_done,
  input  logic [IW-1:0]      rx_obj,
  input  logic               tx_done,
  input  logic [IW-1:0]      tx_obj,
  input  logic [NUM_OBJ-1:0] rx_irq_en,
  input  logic [NUM_OBJ-1:0] tx_irq_en,
  input  logic               clr_stb,
  input  logic [IW-1:0]      clr_obj,
  input  logic               xfer_ok,
  input  logic               lec_upd,
  input  logic [LEC_W-1:0]   lec_code,
  input  logic               bus_off,
  input  logic               err_warn,
  input  logic               stat_rd,
  output logic [ID_W-1:0]    int_id,
  output logic               irq_n,
  output logic [NUM_OBJ-1:0] obj_pend
);
  logic [1:0] rst_sync;
  logic       rst_i_n;
  logic       stat_pend;

  // asserted at once, released two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  pend_bank #(.NUM_OBJ(NUM_OBJ)) u_pend (
    .clk(clk), .rst_n(rst_i_n),
    .rx_done(rx_done), .rx_obj(rx_obj),
    .tx_done(tx_done), .tx_obj(tx_obj),
    .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
    .clr_stb(clr_stb), .clr_obj(clr_obj),
    .pend(obj_pend)
  );

  stat_src u_stat (
    .clk(clk), .rst_n(rst_i_n),
    .stat_chg_en(stat_chg_en), .err_chg_en(err_chg_en),
    .xfer_ok(xfer_ok), .lec_upd(lec_upd), .lec_code(lec_code),
    .bus_off(bus_off), .err_warn(err_warn), .stat_rd(stat_rd),
    .stat_pend(stat_pend)
  );

  id_encode #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .STAT_ID(ID_W'(1) << (ID_W - 1))) u_enc (
    .clk(clk), .rst_n(rst_i_n),
    .pend(obj_pend), .stat_pend(stat_pend),
    .int_id(int_id)
  );

  always_comb irq_n = !(irq_en && (int_id != '0));

  // R11: any source pending in the previous cycle pulls the line low
  a_r11_line_low: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_en && ($past(obj_pend != '0) || $past(stat_pend))) |-> !irq_n);
endmodule

// File: tb/sim_msg_irq_ident.sv
module sim_msg_irq_ident;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_en, stat_chg_en, err_chg_en;
  logic        rx_done, tx_done, clr_stb;
  logic [4:0]  rx_obj, tx_obj, clr_obj;
  logic [31:0] rx_irq_en, tx_irq_en;
  logic        xfer_ok, lec_upd, bus_off, err_warn, stat_rd;
  logic [2:0]  lec_code;
  logic [15:0] int_id;
  logic        irq_n;
  logic [31:0] obj_pend;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_pend;
  logic        m_stat, m_boff, m_warn;

  always #10 clk = ~clk;

  msg_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .stat_chg_en(stat_chg_en),
    .err_chg_en(err_chg_en), .rx_done(rx_done), .rx_obj(rx_obj),
    .tx_done(tx_done), .tx_obj(tx_obj), .rx_irq_en(rx_irq_en),
    .tx_irq_en(tx_irq_en), .clr_stb(clr_stb), .clr_obj(clr_obj),
    .xfer_ok(xfer_ok), .lec_upd(lec_upd), .lec_code(lec_code),
    .bus_off(bus_off), .err_warn(err_warn), .stat_rd(stat_rd),
    .int_id(int_id), .irq_n(irq_n), .obj_pend(obj_pend)
  );

  function automatic logic [15:0] enc(input logic [31:0] p, input logic s);
    logic [15:0] r;
    r = 16'h0000;
    for (int i = 31; i >= 0; i--) if (p[i]) r = 16'(i + 1);
    if (s) r = 16'h8000;
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulses_off();
    rx_done = 0; tx_done = 0; clr_stb = 0; xfer_ok = 0; lec_upd = 0; stat_rd = 0;
  endtask

  // inputs are already driven (after a negedge); advance one cycle and compare
  task automatic step(input string tag);
    logic [15:0] exp_id;
    logic [31:0] nxt;
    logic        sset;
    exp_id = enc(m_pend, m_stat);
    nxt = m_pend;
    for (int i = 0; i < 32; i++) begin
      if (clr_stb && clr_obj == 5'(i)) nxt[i] = 1'b0;
      if ((rx_done && rx_obj == 5'(i) && rx_irq_en[i]) ||
          (tx_done && tx_obj == 5'(i) && tx_irq_en[i])) nxt[i] = 1'b1;
    end
    sset = (stat_chg_en && (xfer_ok || (lec_upd && lec_code != 3'd0 && lec_code != 3'd7))) ||
           (err_chg_en && ((bus_off != m_boff) || (err_warn != m_warn)));
    m_stat = sset || (m_stat && !stat_rd);
    m_boff = bus_off;
    m_warn = err_warn;
    m_pend = nxt;
    @(posedge clk);
    @(negedge clk);
    chk(obj_pend == m_pend, {tag, " R12 obj_pend"}, obj_pend, m_pend);
    chk(int_id == exp_id, {tag, " R12 int_id"}, 32'(int_id), 32'(exp_id));
    chk(irq_n == !(irq_en && exp_id != 0), {tag, irq_en ? " R11 irq_n" : " R10 irq_n"},
        32'(irq_n), 32'(!(irq_en && exp_id != 0)));
    pulses_off();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; irq_en = 0; stat_chg_en = 0; err_chg_en = 0;
    rx_obj = 0; tx_obj = 0; clr_obj = 0; lec_code = 0; bus_off = 0; err_warn = 0;
    rx_irq_en = 32'h0000_0014; tx_irq_en = 32'h0000_0200;
    pulses_off();
    m_pend = 0; m_stat = 0; m_boff = 0; m_warn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(int_id == 0, "R13 reset int_id", 32'(int_id), 0);
    chk(irq_n == 1, "R13 reset irq_n", 32'(irq_n), 1);
    chk(obj_pend == 0, "R13 reset obj_pend", obj_pend, 0);
    step("R1 idle");

    // R4/R12: object 5 (index 4) pending one cycle before its code
    irq_en = 1;
    rx_done = 1; rx_obj = 5'd4;
    step("R4 rx set");
    chk(int_id == 0, "R12 id lags", 32'(int_id), 0);
    step("R12 follow");
    chk(int_id == 16'd5, "R2 single object", 32'(int_id), 5);

    // R4 ignored reception, R5 gated transmission
    rx_done = 1; rx_obj = 5'd9;
    step("R4 disabled rx");
    chk(obj_pend[9] == 0, "R4 disabled rx ignored", 32'(obj_pend[9]), 0);
    tx_done = 1; tx_obj = 5'd9;
    step("R5 tx set");
    chk(obj_pend[9] == 1, "R5 tx enabled", 32'(obj_pend[9]), 1);
    tx_done = 1; tx_obj = 5'd4 + 5'd1;
    step("R5 disabled tx");
    chk(obj_pend[5] == 0, "R5 disabled tx ignored", 32'(obj_pend[5]), 0);

    // R2 lowest index wins
    rx_done = 1; rx_obj = 5'd2;
    step("R2 lower");
    step("R2 lower");
    chk(int_id == 16'd3, "R2 lowest wins", 32'(int_id), 3);

    // R7 codes 7 and 0 do nothing, code 3 latches
    stat_chg_en = 1;
    lec_upd = 1; lec_code = 3'd7;
    step("R7 code7");
    lec_upd = 1; lec_code = 3'd0;
    step("R7 code0");
    step("R7 code0");
    chk(int_id == 16'd3, "R7 codes 0/7 ignored", 32'(int_id), 3);
    lec_upd = 1; lec_code = 3'd3;
    step("R7 bus err");
    step("R3 status");
    chk(int_id == 16'h8000, "R3 status outranks", 32'(int_id), 32'h8000);

    // R9 read clears status; simultaneous event wins
    stat_rd = 1; xfer_ok = 1;
    step("R9 read+set");
    step("R9 read+set");
    chk(int_id == 16'h8000, "R9 set beats read", 32'(int_id), 32'h8000);
    stat_rd = 1;
    step("R9 read");
    step("R9 read");
    chk(int_id == 16'd3, "R9 read clears", 32'(int_id), 3);

    // R8 busoff and warning edges
    stat_chg_en = 0; err_chg_en = 1;
    bus_off = 1;
    step("R8 boff rise");
    stat_rd = 1;
    step("R8 read");
    err_warn = 1;
    step("R8 warn rise");
    stat_rd = 1;
    step("R8 read");
    err_warn = 0;
    step("R8 warn fall");
    step("R8 warn fall");
    chk(int_id == 16'h8000, "R8 warn fall", 32'(int_id), 32'h8000);
    stat_rd = 1;
    step("R8 read");

    // R6 clears, set beats clear, R11 line released
    clr_stb = 1; clr_obj = 5'd2; rx_done = 1; rx_obj = 5'd2;
    step("R6 set beats clear");
    chk(obj_pend[2] == 1, "R6 set beats clear", 32'(obj_pend[2]), 1);
    clr_stb = 1; clr_obj = 5'd2; step("R6 clear");
    clr_stb = 1; clr_obj = 5'd4; step("R6 clear");
    clr_stb = 1; clr_obj = 5'd9; step("R6 clear");
    step("R11 release");
    chk(irq_n == 1 && int_id == 0, "R11 all cleared", {int_id, 15'd0, irq_n}, 32'h1);

    // R10 line held high with a source pending
    rx_done = 1; rx_obj = 5'd4; irq_en = 0;
    step("R10 disabled");
    step("R10 disabled");
    chk(irq_n == 1, "R10 line high", 32'(irq_n), 1);

    // constrained random
    rx_irq_en = $urandom(); tx_irq_en = $urandom();
    for (int n = 0; n < 3000; n++) begin
      irq_en      = ($urandom_range(0, 9) != 0);
      stat_chg_en = $urandom_range(0, 1);
      err_chg_en  = $urandom_range(0, 1);
      rx_done = ($urandom_range(0, 3) == 0); rx_obj = 5'($urandom());
      tx_done = ($urandom_range(0, 3) == 0); tx_obj = 5'($urandom());
      clr_stb = ($urandom_range(0, 1) == 0); clr_obj = 5'($urandom());
      xfer_ok = ($urandom_range(0, 15) == 0);
      lec_upd = ($urandom_range(0, 7) == 0); lec_code = 3'($urandom());
      if ($urandom_range(0, 15) == 0) bus_off = ~bus_off;
      if ($urandom_range(0, 15) == 0) err_warn = ~err_warn;
      stat_rd = ($urandom_range(0, 2) == 0);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule